// File: doc/BRIEF.md
# Legacy Keyboard Port Emulation Registers

This block stands in for the legacy keyboard controller's data port (I/O 60h) and command/status port (I/O 64h). While emulation is on, it claims I/O cycles to those two addresses. Writes to either port latch a byte for the emulation software. A read of the data port returns a byte that the software placed there earlier. A read of the command port returns a status byte. Each of these port accesses updates the status bits as a side effect. The same three registers (input byte, output byte, status) are also reachable through a plain memory-mapped register interface, which never causes side effects.

From the status register the block derives two legacy interrupt requests: a keyboard request and an auxiliary-device request. Which one is raised depends on the auxiliary flag. It also produces an emulation interrupt that tells the software there is work to do. The enable inputs come from a control register outside this block.

A small state machine follows the A20 gate command sequence, so that the writes belonging to it do not raise the input-full flag. The tracker has three states:
- `A20_IDLE`: no sequence in progress.
- `A20_CMD`: a D1h was written to the command port.
- `A20_DATA`: after that, a byte was written to the data port.

Its transitions are:
- IDLE→CMD on a D1h command write.
- CMD→DATA on a data-port write.
- DATA→IDLE on an FFh command write, which completes the sequence.
- CMD→CMD or DATA→CMD on another D1h command write, which restarts the sequence.
- Back to IDLE on any other claimed access, which aborts the sequence.
- The state holds when there is no claimed access.

Top module: `kbe_port_emu`

## Requirements
- R1: A claimed write to port 60h or 64h stores `io_wdata` in the input-byte register. That register is read as memory index 0, zero-extended to 32 bits.
- R2: A claimed write to port 60h clears status bit 3 (command/data flag). A claimed write to 64h sets it.
- R3: A claimed write to either port sets status bit 1 (input full), unless the write belongs to an A20 gate sequence (R12).
- R4: A claimed read of port 60h returns the output byte in the same cycle on `io_rdata`, and clears status bit 0 (output full) at the next clock edge.
- R5: A claimed read of port 64h returns the status byte in the same cycle. Its bits are: 0 output full, 1 input full, 2 system flag, 3 command/data, 4 inhibit switch, 5 auxiliary full, 6 time-out, 7 parity.
- R6: `irq1` is high while `irq_en`=1, bit0=1 and bit5=0. `irq12` is high while `irq_en`=1, bit0=1 and bit5=1. Both follow status combinationally.
- R7: `emu_irq` is high while (`emu_en`=1 and bit1=1) or (bit0=0 and `char_pend`=1).
- R8: The memory map is: index 0 input byte, 1 output byte, 2 status, 3 reads zero. Bits 31:8 always read zero. Memory reads and writes change no status bit other than by the value written.
- R9: After reset all three registers are zero, and `io_claim`, `io_rdata`, `irq1`, `irq12` and `emu_irq` are low when `char_pend`=0.
- R10: With `emu_en`=0, `io_claim` stays low, `io_rdata` is zero, and I/O accesses change no register.
- R11: When a memory write to a register and an I/O side effect on that register happen in the same cycle, the memory write's value is what gets stored.
- R12: Inside an A20 gate sequence, these writes leave bit 1 unchanged: the D1h command write, the data write that follows it, and the FFh command write that ends it. Any other claimed access returns the tracker to idle, so later writes set bit 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_en | input | 1 | Emulation enable |
| irq_en | input | 1 | Legacy interrupt enable |
| char_pend | input | 1 | Character-pending control flag |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| io_claim | output | 1 | Block responds to this I/O cycle |
| mm_wr | input | 1 | Memory-mapped write strobe |
| mm_idx | input | 2 | Memory-mapped register index |
| mm_wdata | input | 8 | Memory-mapped write data (writable low byte) |
| mm_rdata | output | 32 | Memory-mapped read data (combinational) |
| irq1 | output | 1 | Keyboard interrupt request |
| irq12 | output | 1 | Auxiliary-device interrupt request |
| emu_irq | output | 1 | Emulation interrupt condition |

## Verification
A wrong status bit appears at the ports one edge after the access that caused it. It shows on the next 64h read or the next memory read of index 2. A wrong bit 0 or bit 5 also shows on the interrupt lines in that same cycle. A corrupted A20 tracker state stays hidden until the next command or data write. That write then sets or leaves input full wrongly, which `emu_irq` shows one cycle later. The checks therefore read status through the side-effect-free index after each access, and they use aborted sequences as well as completed ones.

// File: rtl/kbe_pkg.sv
package kbe_pkg;
    typedef enum logic [1:0] {
        A20_IDLE = 2'd0,
        A20_CMD  = 2'd1,
        A20_DATA = 2'd2
    } a20_state_e;

    typedef enum logic [1:0] {
        MM_INPUT  = 2'd0,
        MM_OUTPUT = 2'd1,
        MM_STATUS = 2'd2,
        MM_NONE   = 2'd3
    } mm_sel_e;

    typedef struct packed {
        logic wr_data;
        logic wr_cmd;
        logic rd_data;
        logic rd_cmd;
    } io_evt_t;

    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_CMD  = 3;
    localparam int ST_AUX  = 5;
endpackage

// File: rtl/kbe_a20_seq.sv
module kbe_a20_seq
    import kbe_pkg::*;
#(
    parameter int              BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] CMD_CODE = 8'hD1,
    parameter logic [BYTE_W-1:0] END_CODE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  io_evt_t           evt,
    input  logic [BYTE_W-1:0] wdata,
    output logic              hold_ibf
);
    a20_state_e state_q, state_d;
    logic any_acc, is_start, is_end;

    assign any_acc  = |evt;
    assign is_start = evt.wr_cmd && (wdata == CMD_CODE);
    assign is_end   = evt.wr_cmd && (wdata == END_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= A20_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            A20_IDLE: if (is_start) state_d = A20_CMD;
            A20_CMD: begin
                if (evt.wr_data)   state_d = A20_DATA;
                else if (is_start) state_d = A20_CMD;
                else if (any_acc)  state_d = A20_IDLE;
            end
            A20_DATA: begin
                if (is_end)        state_d = A20_IDLE;
                else if (is_start) state_d = A20_CMD;
                else if (any_acc)  state_d = A20_IDLE;
            end
            default: state_d = A20_IDLE;
        endcase
    end

    always_comb begin
        hold_ibf = 1'b0;
        unique case (state_q)
            A20_IDLE: hold_ibf = is_start;
            A20_CMD:  hold_ibf = evt.wr_data || is_start;
            A20_DATA: hold_ibf = is_end || is_start;
            default:  hold_ibf = 1'b0;
        endcase
    end
endmodule

// File: rtl/kbe_regs.sv
module kbe_regs
    import kbe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  io_evt_t           evt,
    input  logic [BYTE_W-1:0] io_wdata,
    input  logic              hold_ibf,
    input  logic              mm_we,
    input  mm_sel_e           mm_sel,
    input  logic [BYTE_W-1:0] mm_wdata,
    output logic [BYTE_W-1:0] in_q,
    output logic [BYTE_W-1:0] out_q,
    output logic [BYTE_W-1:0] stat_q
);
    logic [BYTE_W-1:0] stat_d;
    logic any_wr;

    assign any_wr = evt.wr_data || evt.wr_cmd;

    always_comb begin
        stat_d = stat_q;
        if (evt.rd_data)           stat_d[ST_OBF] = 1'b0;
        if (any_wr && !hold_ibf)   stat_d[ST_IBF] = 1'b1;
        if (evt.wr_data)           stat_d[ST_CMD] = 1'b0;
        if (evt.wr_cmd)            stat_d[ST_CMD] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q   <= '0;
            out_q  <= '0;
            stat_q <= '0;
        end else begin
            if (mm_we && mm_sel == MM_INPUT) in_q <= mm_wdata;
            else if (any_wr)                 in_q <= io_wdata;
            if (mm_we && mm_sel == MM_OUTPUT) out_q <= mm_wdata;
            if (mm_we && mm_sel == MM_STATUS) stat_q <= mm_wdata;
            else                              stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/kbe_port_emu.sv
module kbe_port_emu
    import kbe_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              BYTE_W    = 8,
    parameter int              REG_W     = 32,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emu_en,
    input  logic              irq_en,
    input  logic              char_pend,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    output logic              io_claim,
    input  logic              mm_wr,
    input  logic [1:0]        mm_idx,
    input  logic [BYTE_W-1:0] mm_wdata,
    output logic [REG_W-1:0]  mm_rdata,
    output logic              irq1,
    output logic              irq12,
    output logic              emu_irq
);
    localparam int PAD_W = REG_W - BYTE_W;

    logic hit_data, hit_cmd, hold_ibf;
    io_evt_t evt;
    mm_sel_e mm_sel;
    logic [BYTE_W-1:0] in_q, out_q, stat_q, mm_byte;

    assign hit_data = (io_addr == DATA_PORT);
    assign hit_cmd  = (io_addr == CMD_PORT);
    assign io_claim = emu_en && (io_wr || io_rd) && (hit_data || hit_cmd);

    assign evt.wr_data = io_claim && io_wr && hit_data;
    assign evt.wr_cmd  = io_claim && io_wr && hit_cmd;
    assign evt.rd_data = io_claim && io_rd && !io_wr && hit_data;
    assign evt.rd_cmd  = io_claim && io_rd && !io_wr && hit_cmd;

    assign mm_sel = mm_sel_e'(mm_idx);

    kbe_a20_seq #(.BYTE_W(BYTE_W)) u_a20 (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wdata    (io_wdata),
        .hold_ibf (hold_ibf)
    );

    kbe_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .io_wdata (io_wdata),
        .hold_ibf (hold_ibf),
        .mm_we    (mm_wr),
        .mm_sel   (mm_sel),
        .mm_wdata (mm_wdata),
        .in_q     (in_q),
        .out_q    (out_q),
        .stat_q   (stat_q)
    );

    always_comb begin
        if (evt.rd_data)     io_rdata = out_q;
        else if (evt.rd_cmd) io_rdata = stat_q;
        else                 io_rdata = '0;
    end

    always_comb begin
        unique case (mm_sel)
            MM_INPUT:  mm_byte = in_q;
            MM_OUTPUT: mm_byte = out_q;
            MM_STATUS: mm_byte = stat_q;
            default:   mm_byte = '0;
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign mm_rdata = {{PAD_W{1'b0}}, mm_byte};
        end else begin : g_nopad
            assign mm_rdata = mm_byte[REG_W-1:0];
        end
    endgenerate

    assign irq1    = irq_en && stat_q[ST_OBF] && !stat_q[ST_AUX];
    assign irq12   = irq_en && stat_q[ST_OBF] &&  stat_q[ST_AUX];
    assign emu_irq = (emu_en && stat_q[ST_IBF]) || (!stat_q[ST_OBF] && char_pend);
endmodule

// File: rtl/kbe_port_emu_chk.sv
module kbe_port_emu_chk #(
    parameter int              ADDR_W    = 16,
    parameter int              BYTE_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
    input logic              clk,
    input logic              rst_n,
    input logic              emu_en,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_claim,
    input logic              mm_wr,
    input logic [1:0]        mm_idx,
    input logic [BYTE_W-1:0] mm_wdata,
    input logic              irq1,
    input logic              irq12,
    input logic [BYTE_W-1:0] stat_q
);
    logic mm_stat_we, on_data, on_cmd;
    assign mm_stat_we = mm_wr && (mm_idx == 2'd2);
    assign on_data = io_claim && (io_addr == DATA_PORT);
    assign on_cmd  = io_claim && (io_addr == CMD_PORT);

    p_claim_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_en |-> !io_claim);

    p_quiet_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!emu_en && !mm_wr) |=> $stable(stat_q));

    p_mm_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mm_wr && !io_claim) |=> $stable(stat_q));

    p_rd_clears_obf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_data && io_rd && !io_wr && !mm_stat_we) |=> !stat_q[0]);

    p_cmd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (on_cmd && io_wr && !mm_stat_we) |=> stat_q[3]);

    p_cmd_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (on_data && io_wr && !mm_stat_we) |=> !stat_q[3]);

    p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq1, irq12}));

    p_mm_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mm_stat_we |=> (stat_q == $past(mm_wdata)));
endmodule

bind kbe_port_emu kbe_port_emu_chk #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .emu_en   (emu_en),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_claim (io_claim),
    .mm_wr    (mm_wr),
    .mm_idx   (mm_idx),
    .mm_wdata (mm_wdata),
    .irq1     (irq1),
    .irq12    (irq12),
    .stat_q   (stat_q)
);

// File: tb/tb_kbe_port_emu.sv
`timescale 1ns/1ps
module tb_kbe_port_emu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        emu_en = 1'b0, irq_en = 1'b0, char_pend = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_claim;
    logic        mm_wr = 1'b0;
    logic [1:0]  mm_idx = 2'd3;
    logic [7:0]  mm_wdata = '0;
    logic [31:0] mm_rdata;
    logic        irq1, irq12, emu_irq;

    int nvec = 0, nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kbe_port_emu dut (
        .clk(clk), .rst_n(rst_n), .emu_en(emu_en), .irq_en(irq_en),
        .char_pend(char_pend), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_claim(io_claim), .mm_wr(mm_wr), .mm_idx(mm_idx),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .irq1(irq1),
        .irq12(irq12), .emu_irq(emu_irq)
    );

    // vector: [25] read, [24] cmd port, [23:16] wdata, [15:8] exp read, [7:0] exp status
    localparam logic [25:0] VEC [6] = '{
        {1'b1, 1'b1, 8'h00, 8'h21, 8'h21},
        {1'b0, 1'b0, 8'h11, 8'h00, 8'h23},
        {1'b0, 1'b1, 8'h20, 8'h00, 8'h2B},
        {1'b1, 1'b0, 8'h00, 8'h5A, 8'h2A},
        {1'b1, 1'b1, 8'h00, 8'h2A, 8'h2A},
        {1'b1, 1'b0, 8'h00, 8'h5A, 8'h2A}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic io_op(input bit rd, input bit cmd, input logic [7:0] d,
                         output logic [7:0] rv, output logic cl);
        @(negedge clk);
        io_addr = cmd ? 16'h0064 : 16'h0060;
        io_wdata = d; io_wr = !rd; io_rd = rd;
        #1 rv = io_rdata; cl = io_claim;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic mm_poke(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        mm_wr = 1'b1; mm_idx = idx; mm_wdata = d;
        @(negedge clk);
        mm_wr = 1'b0; mm_idx = 2'd3;
    endtask

    task automatic mm_peek(input logic [1:0] idx, output logic [31:0] v);
        mm_idx = idx;
        #1 v = mm_rdata;
        mm_idx = 2'd3;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic cl;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 claim", {31'b0, io_claim}, 32'h0);
        check("R9 irqs", {29'b0, irq1, irq12, emu_irq}, 32'h0);
        check("R9 io_rdata", {24'b0, io_rdata}, 32'h0);
        mm_peek(2'd0, v); check("R9 input", v, 32'h0);
        mm_peek(2'd1, v); check("R9 output", v, 32'h0);
        mm_peek(2'd2, v); check("R9 status", v, 32'h0);

        // table walk: R4 R5 R2 R3
        emu_en = 1'b1;
        mm_poke(2'd1, 8'h5A);
        mm_poke(2'd2, 8'h21);
        foreach (VEC[i]) begin
            io_op(VEC[i][25], VEC[i][24], VEC[i][23:16], rv, cl);
            check($sformatf("R10 claim v%0d", i), {31'b0, cl}, 32'h1);
            if (VEC[i][25]) check($sformatf("R4/R5 read v%0d", i), {24'b0, rv}, {24'b0, VEC[i][15:8]});
            mm_peek(2'd2, v);
            check($sformatf("R2/R3 status v%0d", i), v, {24'b0, VEC[i][7:0]});
        end
        // R1 last write captured byte 20h
        mm_peek(2'd0, v); check("R1 input byte", v, 32'h20);

        // R6 steering
        irq_en = 1'b1;
        mm_poke(2'd2, 8'h01); #1;
        check("R6 kbd irq", {30'b0, irq1, irq12}, 32'h2);
        mm_poke(2'd2, 8'h21); #1;
        check("R6 aux irq", {30'b0, irq1, irq12}, 32'h1);
        irq_en = 1'b0; #1;
        check("R6 disabled", {30'b0, irq1, irq12}, 32'h0);

        // R7 emulation interrupt
        mm_poke(2'd2, 8'h03); #1;
        check("R7 ibf", {31'b0, emu_irq}, 32'h1);
        mm_poke(2'd2, 8'h01); char_pend = 1'b1; #1;
        check("R7 obf blocks pend", {31'b0, emu_irq}, 32'h0);
        mm_poke(2'd2, 8'h00); #1;
        check("R7 pending", {31'b0, emu_irq}, 32'h1);
        char_pend = 1'b0;

        // R12 full A20 sequence leaves input full clear
        io_op(1'b0, 1'b1, 8'hD1, rv, cl); mm_peek(2'd2, v); check("R12 D1", v, 32'h08);
        io_op(1'b0, 1'b0, 8'hDF, rv, cl); mm_peek(2'd2, v); check("R12 data", v, 32'h00);
        io_op(1'b0, 1'b1, 8'hFF, rv, cl); mm_peek(2'd2, v); check("R12 FF", v, 32'h08);
        mm_peek(2'd0, v); check("R1 A20 byte", v, 32'hFF);
        io_op(1'b0, 1'b1, 8'hAA, rv, cl); mm_peek(2'd2, v); check("R3 after seq", v, 32'h0A);

        // R12 aborted sequence
        mm_poke(2'd2, 8'h00);
        io_op(1'b0, 1'b1, 8'hD1, rv, cl);
        io_op(1'b1, 1'b1, 8'h00, rv, cl);
        io_op(1'b0, 1'b0, 8'h00, rv, cl); mm_peek(2'd2, v); check("R12 abort", v, 32'h02);

        // R10 disabled
        mm_poke(2'd2, 8'h01);
        emu_en = 1'b0;
        io_op(1'b0, 1'b0, 8'h77, rv, cl);
        check("R10 no claim", {31'b0, cl}, 32'h0);
        mm_peek(2'd2, v); check("R10 status kept", v, 32'h01);
        mm_peek(2'd0, v); check("R10 input kept", v, 32'h00);
        io_op(1'b1, 1'b0, 8'h00, rv, cl);
        check("R10 rdata zero", {24'b0, rv}, 32'h0);
        mm_peek(2'd2, v); check("R10 obf kept", v, 32'h01);

        // R8 memory reads are free of effects, upper bits zero
        emu_en = 1'b1;
        repeat (3) begin @(negedge clk); mm_peek(2'd1, v); end
        mm_peek(2'd2, v); check("R8 obf after mm reads", v, 32'h01);
        mm_poke(2'd1, 8'hFF);
        mm_peek(2'd1, v); check("R8 upper zero", v, 32'h0000_00FF);
        mm_peek(2'd3, v); check("R8 index 3", v, 32'h0);

        // R11 same-cycle priority
        @(negedge clk);
        io_addr = 16'h0064; io_wdata = 8'h55; io_wr = 1'b1;
        mm_wr = 1'b1; mm_idx = 2'd2; mm_wdata = 8'h40;
        @(negedge clk);
        io_wr = 1'b0; mm_wr = 1'b0; mm_idx = 2'd3;
        mm_peek(2'd2, v); check("R11 mm wins", v, 32'h40);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule